// File: doc/BRIEF.md
# I2C Master SCL Clock Generator

This block produces the serial clock of an I2C master. It drives an open-drain line by pulling it low or letting it go. A prescaler turns the system clock into an oversampling tick. Two programmable tick counts set how long the block holds SCL low and how long it lets SCL stay high. After the low phase the block releases the line, then waits for a synchronized and filtered copy of the line to read high. Only then does it start timing the high phase. A slow pull-up, a heavy load or a slave that holds the clock low therefore stretches only the released part of the period, and the low part stays fixed. A data shifter next to the block uses two single-cycle strobes. One marks the start of each low phase, where SDA may change. The other marks the middle of each high phase, where SDA is sampled. A timeout raises a stretch error if the line never comes back high.

The state machine has four states. PH_IDLE parks with the line released. PH_LOW drives the line low. PH_RISE has the line released and waits for it to read high. PH_HIGH times the high phase. The transitions are:
- start: PH_IDLE to PH_LOW, when enable is high and no error is latched.
- release: PH_LOW to PH_RISE, on the last low tick.
- seen-high: PH_RISE to PH_HIGH, when the filtered line reads high.
- timeout: PH_RISE to PH_IDLE, when the stretch limit expires.
- next-cycle: PH_HIGH to PH_LOW, on the last high tick with enable high.
- park: PH_HIGH to PH_IDLE, on the last high tick with enable low.

Configuration limits: `presc_div` ≥ 1, `low_cnt` × `presc_div` ≥ 4, `high_cnt` ≥ 2, `filt_len` ≥ 1 and `stretch_limit` ≥ 1.

Top module: `scl_clkgen`

## Requirements
- R1: While reset is asserted, and after reset with enable low, `scl_drive_low`, both strobes and `stretch_err` are 0.
- R2: Each low phase lasts exactly `low_cnt` × `presc_div` clock cycles. `strobe_low_start` is 1 in the first cycle of the low phase and only there.
- R3: The released part of each period lasts R + `filt_len` + 3 + `high_cnt` × `presc_div` cycles. R is the number of cycles the line takes to read high after release. The 3 cycles are two synchronizer flops plus one state-register cycle.
- R4: Swapping the low and high counts, with the same sum and the same line, leaves the total period unchanged.
- R5: A high on the line shorter than `filt_len` consecutive synchronized samples is ignored, and the released-phase length is unchanged.
- R6: `strobe_high_mid` pulses exactly once per released phase, while SCL is released.
- R7: If the line is still low `stretch_limit` ticks after release, `stretch_err` goes to 1 in cycle `stretch_limit` × `presc_div` of the released phase. The line stays released and no new low phase starts. The error clears one cycle after enable is low.
- R8: When enable is deasserted, the current cycle finishes its high phase, and then no further low phase is driven.
- R9: With the block idle, `scl_drive_low` goes to 1 in the cycle after enable is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Start or continue clock generation |
| presc_div | input | PRESC_W | System clocks per oversample tick |
| low_cnt | input | CNT_W | Low-phase length in ticks |
| high_cnt | input | CNT_W | High-phase length in ticks |
| filt_len | input | FILT_W | Consecutive high samples needed to accept a high |
| stretch_limit | input | TO_W | Ticks allowed for the line to rise after release |
| scl_in | input | 1 | Sensed SCL line level |
| scl_drive_low | output | 1 | Open-drain pull-down enable |
| strobe_low_start | output | 1 | One-cycle pulse at the start of the low phase |
| strobe_high_mid | output | 1 | One-cycle pulse at the middle of the high phase |
| stretch_err | output | 1 | Line failed to rise within the limit |

## Verification
A table of rows, each with a different prescaler, low/high split, filter length and modeled rise delay, drives the main function. The rows separate the fixed low timing from the rise-dependent released timing. Two rows swap the same split to show the period does not change. One row injects a short high glitch, which separates a working filter from one that accepts single samples. Directed runs then cover a line that never rises (the timeout), deasserting enable part-way through a cycle, and the reset state.

// File: rtl/scl_clkgen_pkg.sv
package scl_clkgen_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_RISE = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;
endpackage

// File: rtl/scl_tick_gen.sv
module scl_tick_gen #(
    parameter int PRESC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic [PRESC_W-1:0] div,
    output logic               tick
);
    localparam logic [PRESC_W-1:0] ONE = PRESC_W'(1);

    logic [PRESC_W-1:0] pcnt_q;

    // Tick in the last cycle of each group of div cycles
    assign tick = (pcnt_q == div - ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt_q <= '0;
        else if (clr || tick)
            pcnt_q <= '0;
        else
            pcnt_q <= pcnt_q + ONE;
    end
endmodule

// File: rtl/scl_line_filter.sv
module scl_line_filter #(
    parameter int FILT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_in,
    input  logic [FILT_W-1:0] need,
    output logic              line_high
);
    localparam logic [FILT_W-1:0] RUN_MAX = '1;

    logic              sync1_q, sync2_q;
    logic [FILT_W-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            run_q   <= '0;
        end else begin
            sync1_q <= line_in;
            sync2_q <= sync1_q;
            if (!sync2_q)
                run_q <= '0;
            else if (run_q != RUN_MAX)
                run_q <= run_q + FILT_W'(1);
        end
    end

    assign line_high = (run_q >= need);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_clkgen_pkg::*;
#(
    parameter int PRESC_W = 8,
    parameter int CNT_W   = 8,
    parameter int FILT_W  = 3,
    parameter int TO_W    = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [PRESC_W-1:0] presc_div,
    input  logic [CNT_W-1:0]   low_cnt,
    input  logic [CNT_W-1:0]   high_cnt,
    input  logic [FILT_W-1:0]  filt_len,
    input  logic [TO_W-1:0]    stretch_limit,
    input  logic               scl_in,
    output logic               scl_drive_low,
    output logic               strobe_low_start,
    output logic               strobe_high_mid,
    output logic               stretch_err
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [TO_W-1:0]  TO_ONE  = TO_W'(1);

    scl_phase_e        state_q, state_d;
    logic              tick, clr, line_high;
    logic [CNT_W-1:0]  cnt_q;
    logic [TO_W-1:0]   to_q;
    logic              low_done, high_done, to_hit, mid_hit;

    assign clr = (state_d != state_q) || (state_q == PH_IDLE);

    scl_tick_gen #(.PRESC_W(PRESC_W)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .div   (presc_div),
        .tick  (tick)
    );

    scl_line_filter #(.FILT_W(FILT_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (scl_in),
        .need      (filt_len),
        .line_high (line_high)
    );

    assign low_done  = tick && (cnt_q == low_cnt - CNT_ONE);
    assign high_done = tick && (cnt_q == high_cnt - CNT_ONE);
    assign mid_hit   = tick && (cnt_q == ((high_cnt - CNT_ONE) >> 1));
    assign to_hit    = (state_q == PH_RISE) && !line_high && tick
                       && (to_q == stretch_limit - TO_ONE);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (enable && !stretch_err) state_d = PH_LOW;
            PH_LOW:  if (low_done)               state_d = PH_RISE;
            PH_RISE: begin
                if (line_high)   state_d = PH_HIGH;
                else if (to_hit) state_d = PH_IDLE;
            end
            PH_HIGH: if (high_done) state_d = enable ? PH_LOW : PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    // State register and phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            to_q    <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= '0;
                to_q  <= '0;
            end else if (tick) begin
                cnt_q <= cnt_q + CNT_ONE;
                to_q  <= to_q + TO_ONE;
            end
        end
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_drive_low    <= 1'b0;
            strobe_low_start <= 1'b0;
            strobe_high_mid  <= 1'b0;
            stretch_err      <= 1'b0;
        end else begin
            scl_drive_low    <= (state_d == PH_LOW);
            strobe_low_start <= (state_d == PH_LOW) && (state_q != PH_LOW);
            strobe_high_mid  <= (state_q == PH_HIGH) && mid_hit;
            if (to_hit)
                stretch_err <= 1'b1;
            else if (!enable)
                stretch_err <= 1'b0;
        end
    end
endmodule

// File: rtl/scl_clkgen_checker.sv
module scl_clkgen_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic scl_drive_low,
    input logic strobe_low_start,
    input logic strobe_high_mid,
    input logic stretch_err
);
    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (!scl_drive_low && !strobe_low_start
                                           && !strobe_high_mid && !stretch_err);
        end
    end

    assert_lowstart_in_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_low_start |-> scl_drive_low);

    assert_lowstart_at_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_drive_low && !$past(scl_drive_low)) |-> strobe_low_start);

    assert_mid_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_high_mid |-> !scl_drive_low);

    assert_mid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_high_mid |=> !strobe_high_mid);

    assert_err_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_err |-> !scl_drive_low);

    assert_err_holds_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        stretch_err |=> !scl_drive_low);

    assert_err_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_err && !enable) |=> !stretch_err);
endmodule

bind scl_clkgen scl_clkgen_checker u_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .enable           (enable),
    .scl_drive_low    (scl_drive_low),
    .strobe_low_start (strobe_low_start),
    .strobe_high_mid  (strobe_high_mid),
    .stretch_err      (stretch_err)
);

// File: tb/scl_clkgen_tb_top.sv
`timescale 1ns/1ps
module scl_clkgen_tb_top;
    localparam int PRESC_W = 8;
    localparam int CNT_W   = 8;
    localparam int FILT_W  = 3;
    localparam int TO_W    = 12;
    localparam int NROWS   = 7;
    // Columns: div, low, high, filter, rise delay, glitch position (-1 = none)
    localparam int VEC [NROWS][6] = '{
        '{2, 11,  9, 2,  0, -1},
        '{2, 11,  9, 2,  7, -1},
        '{2,  9, 11, 2,  0, -1},
        '{1,  6,  4, 1,  3, -1},
        '{3,  5,  5, 3, 12, -1},
        '{4, 13,  6, 2, 20, -1},
        '{2, 11,  9, 2, 10,  2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic [PRESC_W-1:0] presc_div = PRESC_W'(2);
    logic [CNT_W-1:0]   low_cnt   = CNT_W'(11);
    logic [CNT_W-1:0]   high_cnt  = CNT_W'(9);
    logic [FILT_W-1:0]  filt_len  = FILT_W'(2);
    logic [TO_W-1:0]    stretch_limit = TO_W'(4000);
    logic scl_in;
    logic scl_drive_low, strobe_low_start, strobe_high_mid, stretch_err;

    int rise_r = 0;
    int glitch_g = -1;
    int rel_cnt = 0;
    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    // Line model: pulled low at once, reads high rise_r cycles after release
    always_ff @(posedge clk) begin
        if (scl_drive_low) rel_cnt <= 0;
        else if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
    end
    assign scl_in = !scl_drive_low && ((rel_cnt >= rise_r) || (rel_cnt == glitch_g));

    scl_clkgen #(.PRESC_W(PRESC_W), .CNT_W(CNT_W), .FILT_W(FILT_W), .TO_W(TO_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .presc_div(presc_div),
        .low_cnt(low_cnt), .high_cnt(high_cnt), .filt_len(filt_len),
        .stretch_limit(stretch_limit), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .strobe_low_start(strobe_low_start),
        .strobe_high_mid(strobe_high_mid), .stretch_err(stretch_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic setup(input int d, input int l, input int h, input int n,
                         input int r, input int g, input int lim);
        enable = 1'b0;
        rst_n  = 1'b0;
        presc_div = PRESC_W'(d);
        low_cnt   = CNT_W'(l);
        high_cnt  = CNT_W'(h);
        filt_len  = FILT_W'(n);
        stretch_limit = TO_W'(lim);
        rise_r = r;
        glitch_g = g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Starts at the first low cycle; ends at the first low cycle of the next period
    task automatic measure(output int lo, output int rel, output int mids, output int ls);
        lo = 1; rel = 0; mids = 0;
        ls = int'(strobe_low_start);
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (!scl_drive_low) break;
            lo++;
        end
        for (int i = 0; i < 5000; i++) begin
            if (scl_drive_low) break;
            rel++;
            mids += int'(strobe_high_mid);
            @(negedge clk);
        end
    endtask

    initial begin
        int lo, rel, mids, ls, per0, per2, d, l, h, n, r, cnt, errs;
        per0 = 0; per2 = 0;

        // R1: reset state
        repeat (2) @(negedge clk);
        chk("R1 drive in reset", int'(scl_drive_low), 0);
        chk("R1 strobes in reset", int'(strobe_low_start | strobe_high_mid), 0);
        chk("R1 err in reset", int'(stretch_err), 0);
        rst_n = 1'b1;
        cnt = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            cnt += int'(scl_drive_low | strobe_low_start | strobe_high_mid | stretch_err);
        end
        chk("R1 quiet with enable low", cnt, 0);

        // Table of vectors: R2, R3, R5, R6, R9
        for (int row = 0; row < NROWS; row++) begin
            d = VEC[row][0]; l = VEC[row][1]; h = VEC[row][2];
            n = VEC[row][3]; r = VEC[row][4];
            setup(d, l, h, n, r, VEC[row][5], 4000);
            enable = 1'b1;
            @(negedge clk);
            chk($sformatf("R9 start row %0d", row), int'(scl_drive_low), 1);
            measure(lo, rel, mids, ls);
            measure(lo, rel, mids, ls);
            chk($sformatf("R2 low length row %0d", row), lo, l * d);
            chk($sformatf("R2 low strobe row %0d", row), ls, 1);
            chk($sformatf("R3 R5 released length row %0d", row), rel, r + n + 3 + h * d);
            chk($sformatf("R6 mid strobes row %0d", row), mids, 1);
            if (row == 0) per0 = lo + rel;
            if (row == 2) per2 = lo + rel;
        end
        chk("R4 split keeps period", per2, per0);

        // R7: line never rises
        setup(2, 11, 9, 2, 100000, -1, 5);
        enable = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 200 && scl_drive_low; i++) @(negedge clk);
        cnt = 0;
        for (int i = 0; i < 200 && !stretch_err; i++) begin
            cnt++;
            @(negedge clk);
        end
        chk("R7 timeout cycle", cnt, 5 * 2);
        cnt = 0; errs = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            cnt += int'(scl_drive_low);
            errs += int'(stretch_err);
        end
        chk("R7 line stays released", cnt, 0);
        chk("R7 error held", errs, 50);
        enable = 1'b0;
        @(negedge clk);
        chk("R7 error clears", int'(stretch_err), 0);

        // R8: enable dropped during a low phase
        setup(2, 6, 4, 1, 0, -1, 4000);
        enable = 1'b1;
        @(negedge clk);
        repeat (2) @(negedge clk);
        enable = 1'b0;
        for (int i = 0; i < 200 && scl_drive_low; i++) @(negedge clk);
        mids = 0; cnt = 0;
        for (int i = 0; i < 200; i++) begin
            mids += int'(strobe_high_mid);
            cnt += int'(scl_drive_low);
            @(negedge clk);
        end
        chk("R8 last high phase completes", mids, 1);
        chk("R8 no further low phase", cnt, 0);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule